// File: doc/BRIEF.md
# I2C Transmit Byte Queue with NAK Hold

This block is a byte queue placed in front of an I2C byte shifter. Software loads bytes one at a time through a data register while the queue is switched on. The queue hands them to the shifter over a valid/ready stream, one at a time. It then waits for the shifter to report whether the target acknowledged the byte. Address bytes and bus START and STOP conditions come from a separate command sequencer. This block carries payload bytes only.

A negative acknowledge stops draining at once and raises a NAK status flag. The bytes not yet sent stay in the queue. Draining resumes only after software writes the flush bit and the enable bit together: this empties the queue and clears the halt. The block also holds a sticky interrupt status register. Its valid bits are write-1-to-clear and its reserved bits always read as zero. An enable register masks the status bits, and the enabled bits are ORed into a single interrupt line.

Stream rules: `tx_valid` is high only while the queue is on, not empty, not halted and has no byte waiting for its acknowledge. Once `tx_valid` is high it keeps `tx_byte` stable until `tx_ready` is seen. There is one exception: a control register write in that cycle may withdraw the byte. After a handshake, no further byte is offered until a pulse on `ack_valid` returns the acknowledge result.

Top module: `i2c_txq`

Register map (3-bit `reg_addr`): 0 = data (write pushes a byte, reads 0), 1 = control (bit 7 flush, self-clearing; bit 6 enable), 2 = queue status (bit 4 empty), 3 = interrupt enable, 4 = interrupt status.

## Requirements
- R1: After reset the queue status reads 0x10 (empty), the control, interrupt status and interrupt enable registers read 0, and `tx_valid` and `irq` are low.
- R2: Bytes written to register 0 while control bit 6 is set leave on `tx_byte` in the order they were written, one per valid/ready handshake.
- R3: A data write while control bit 6 is clear is dropped, and the queue status still reads empty.
- R4: The queue holds DEPTH (64) bytes. A write into a full queue is dropped, so exactly the first 64 bytes drain, in order.
- R5: After a handshake, `tx_valid` stays low until an `ack_valid` pulse arrives. Only one byte is in flight at a time.
- R6: An acknowledge with `ack_nak`=1 sets interrupt status bit 0 and stops draining. The remaining bytes are kept (status bit 4 reads 0) until a control write with bit 7 and bit 6 both set. That write empties the queue and lets later bytes drain again.
- R7: Interrupt status bit 1 is set when a handshake removes the last byte in the queue.
- R8: Interrupt status bits clear when a 1 is written to them. Writing 0 leaves them unchanged.
- R9: Only interrupt status bits 0, 1, 2, 3, 4 and 7 exist. Bits 5, 6 and 8–31 read 0 at all times.
- R10: Only interrupt enable bits 0, 1, 3 and 4 are writable. `irq` is high exactly when some status bit has its enable bit set.
- R11: A pulse on `ext_evt` bits 0, 1, 2 and 3 sets interrupt status bit 2 (error), bit 3 (session done), bit 4 (read complete) and bit 7 (command busy) respectively.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_byte` hold in the next cycle, unless the control register was written.
- R13: Clearing control bit 6 withdraws `tx_valid` but keeps the queued bytes. Setting it again resumes draining from the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of selected register (combinational) |
| tx_valid | output | 1 | Byte offered to shifter |
| tx_ready | input | 1 | Shifter accepts the byte |
| tx_byte | output | 8 | Byte offered to shifter |
| ack_valid | input | 1 | Shifter finished a byte, acknowledge result valid |
| ack_nak | input | 1 | Target did not acknowledge the byte |
| ext_evt | input | 4 | Event pulses from the command sequencer |
| irq | output | 1 | Interrupt line |

## Verification
The assertions take for granted that the shifter pulses `ack_valid` only for a byte it has taken. They also assume it never raises `ack_valid` in the same cycle as a handshake. The stream hold property assumes the byte can be withdrawn only in a cycle with a control register write. The bench's shifter model raises `tx_ready` for a single cycle per byte. It sends the acknowledge one cycle after the handshake and writes the control register only between bytes. A full-depth fill with one overflow write covers every entry of the queue.

// File: rtl/i2c_txq_pkg.sv
package i2c_txq_pkg;
  localparam int RegAw = 3;
  localparam logic [RegAw-1:0] ADDR_DATA  = 3'd0;
  localparam logic [RegAw-1:0] ADDR_CTRL  = 3'd1;
  localparam logic [RegAw-1:0] ADDR_QSTAT = 3'd2;
  localparam logic [RegAw-1:0] ADDR_IEN   = 3'd3;
  localparam logic [RegAw-1:0] ADDR_ISTAT = 3'd4;

  localparam int CTRL_FLUSH_BIT = 7;
  localparam int CTRL_EN_BIT    = 6;
  localparam int QSTAT_EMPTY_BIT = 4;

  localparam int IS_NAK   = 0;
  localparam int IS_EMPTY = 1;
  localparam int IS_ERR   = 2;
  localparam int IS_SESS  = 3;
  localparam int IS_RDC   = 4;
  localparam int IS_BUSY  = 7;

  localparam logic [7:0] ISTAT_VALID = 8'h9F;
  localparam logic [7:0] IEN_VALID   = 8'h1B;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4: count never exceeds the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R4: a push into a full queue leaves the count unchanged
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/txq_drain.sv
module txq_drain #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          flush,
  input  logic          ctl_wr,
  input  logic          empty,
  input  logic [DW-1:0] head,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_byte,
  input  logic          ack_valid,
  input  logic          ack_nak,
  output logic          pop,
  output logic          nak_evt
);
  logic waiting, halted;

  assign tx_valid = enable && !empty && !halted && !waiting;
  assign tx_byte  = head;
  assign pop      = tx_valid && tx_ready;
  assign nak_evt  = waiting && ack_valid && ack_nak;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      halted  <= 1'b0;
    end else begin
      if (pop) waiting <= 1'b1;
      else if (ack_valid) waiting <= 1'b0;
      if (flush) halted <= 1'b0;
      else if (nak_evt) halted <= 1'b1;
    end
  end

  // R5: nothing offered while a byte awaits its acknowledge
  a_r5_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !tx_valid);
  // R6: a NAK stops the stream until a flush
  a_r6_nak_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_evt && !flush) |=> !tx_valid);
  // R12: offered byte holds under back-pressure
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !ctl_wr) |=> (tx_valid && $stable(tx_byte)));
endmodule

// File: rtl/txq_irq.sv
module txq_irq
  import i2c_txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_vec,
  input  logic       stat_wr,
  input  logic       ien_wr,
  input  logic [7:0] wdata,
  output logic [7:0] stat,
  output logic [7:0] ien,
  output logic       irq
);
  logic [7:0] clr;

  assign clr = stat_wr ? (wdata & ISTAT_VALID) : 8'h00;
  assign irq = |(stat & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= 8'h00;
      ien  <= 8'h00;
    end else begin
      stat <= ((stat & ~clr) | set_vec) & ISTAT_VALID;
      if (ien_wr) ien <= wdata & IEN_VALID;
    end
  end

  // R9: reserved status bits never set
  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~ISTAT_VALID) == 8'h00);
  // R10: interrupt only from an enabled bit
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != 8'h00));
  // R8: a write-1 clears a bit that no event sets
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata[IS_ERR] && !set_vec[IS_ERR]) |=> !stat[IS_ERR]);
endmodule

// File: rtl/i2c_txq.sv
module i2c_txq
  import i2c_txq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_byte,
  input  logic        ack_valid,
  input  logic        ack_nak,
  input  logic [3:0]  ext_evt,
  output logic        irq
);
  logic enable, flush, ctl_wr, push, pop, empty, full, nak_evt, empty_evt;
  logic [7:0] head, set_vec, stat, ien;
  logic [CW-1:0] count;

  assign ctl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign flush  = ctl_wr && reg_wdata[CTRL_FLUSH_BIT];
  assign push   = reg_wr && (reg_addr == ADDR_DATA) && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) enable <= 1'b0;
    else if (ctl_wr) enable <= reg_wdata[CTRL_EN_BIT];
  end

  txq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .flush(flush),
    .din(reg_wdata[7:0]), .dout(head), .count(count), .empty(empty), .full(full)
  );

  txq_drain #(.DW(8)) u_drain (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush), .ctl_wr(ctl_wr),
    .empty(empty), .head(head), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .ack_valid(ack_valid), .ack_nak(ack_nak),
    .pop(pop), .nak_evt(nak_evt)
  );

  assign empty_evt = pop && (count == CW'(1)) && !push;

  always_comb begin
    set_vec           = 8'h00;
    set_vec[IS_NAK]   = nak_evt;
    set_vec[IS_EMPTY] = empty_evt;
    set_vec[IS_ERR]   = ext_evt[0];
    set_vec[IS_SESS]  = ext_evt[1];
    set_vec[IS_RDC]   = ext_evt[2];
    set_vec[IS_BUSY]  = ext_evt[3];
  end

  txq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .stat_wr(reg_wr && (reg_addr == ADDR_ISTAT)),
    .ien_wr(reg_wr && (reg_addr == ADDR_IEN)),
    .wdata(reg_wdata[7:0]), .stat(stat), .ien(ien), .irq(irq)
  );

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr)
      ADDR_CTRL:  reg_rdata[CTRL_EN_BIT] = enable;
      ADDR_QSTAT: reg_rdata[QSTAT_EMPTY_BIT] = empty;
      ADDR_IEN:   reg_rdata[7:0] = ien;
      ADDR_ISTAT: reg_rdata[7:0] = stat;
      default:    reg_rdata = 32'h0;
    endcase
  end

  // R9: reserved positions read back as zero
  a_r9_read_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_ISTAT) |-> ((reg_rdata & 32'hFFFFFF60) == 32'h0));
  // R3: a write while off never grows the queue
  a_r3_off_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !pop) |=> (count == $past(count) || count == '0));
endmodule

// File: tb/i2c_txq_tb.sv
module i2c_txq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_byte;
  logic ack_valid = 1'b0, ack_nak = 1'b0;
  logic [3:0] ext_evt = 4'h0;
  logic irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  i2c_txq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .ack_valid(ack_valid),
    .ack_nak(ack_nak), .ext_evt(ext_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_one(input string req, input logic [7:0] exp, input logic nak);
    int w = 0;
    while (!tx_valid && w < 50) begin @(negedge clk); w++; end
    chk(req, {31'h0, tx_valid}, 32'h1);
    chk(req, {24'h0, tx_byte}, {24'h0, exp});
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R5", {31'h0, tx_valid}, 32'h0);
    ack_valid = 1'b1; ack_nak = nak;
    @(negedge clk);
    ack_valid = 1'b0; ack_nak = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd2, v); chk("R1", v, 32'h10);
    rd(3'd1, v); chk("R1", v, 32'h0);
    rd(3'd4, v); chk("R1", v, 32'h0);
    rd(3'd3, v); chk("R1", v, 32'h0);
    chk("R1", {30'h0, tx_valid, irq}, 32'h0);
    // R3 push while off
    wr(3'd0, 32'hAA);
    rd(3'd2, v); chk("R3", v, 32'h10);
    // R12 hold under back-pressure, R2 order
    wr(3'd1, 32'h40);
    rd(3'd1, v); chk("R2", v, 32'h40);
    wr(3'd0, 32'h11); wr(3'd0, 32'h22); wr(3'd0, 32'h33);
    for (int i = 0; i < 4; i++) begin
      chk("R12", {23'h0, tx_valid, tx_byte}, {23'h0, 1'b1, 8'h11});
      @(negedge clk);
    end
    send_one("R2", 8'h11, 1'b0);
    rd(3'd4, v); chk("R7", v, 32'h0);
    send_one("R2", 8'h22, 1'b0);
    send_one("R2", 8'h33, 1'b0);
    rd(3'd4, v); chk("R7", v, 32'h02);
    rd(3'd2, v); chk("R2", v, 32'h10);
    // R8 write-1-to-clear
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R8", v, 32'h02);
    wr(3'd4, 32'h02);
    rd(3'd4, v); chk("R8", v, 32'h0);
    // R11 external events, R9 reserved
    ext_evt = 4'hF; @(negedge clk); ext_evt = 4'h0;
    rd(3'd4, v); chk("R11", v, 32'h9C);
    wr(3'd4, 32'hFFFFFFFF);
    rd(3'd4, v); chk("R9", v, 32'h0);
    // R10 enable mask and irq
    wr(3'd3, 32'hFFFFFFFF);
    rd(3'd3, v); chk("R10", v, 32'h1B);
    wr(3'd3, 32'h0);
    ext_evt = 4'h9; @(negedge clk); ext_evt = 4'h0;
    chk("R10", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h04);
    chk("R10", {31'h0, irq}, 32'h0);
    ext_evt = 4'h2; @(negedge clk); ext_evt = 4'h0;
    wr(3'd3, 32'h08);
    chk("R10", {31'h0, irq}, 32'h1);
    wr(3'd4, 32'hFF);
    chk("R10", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h0);
    // R4 full-depth fill plus one dropped write
    for (int i = 0; i < 65; i++) wr(3'd0, (i * 3 + 1) & 8'hFF);
    for (int i = 0; i < 64; i++) send_one("R4", 8'((i * 3 + 1) & 8'hFF), 1'b0);
    rd(3'd2, v); chk("R4", v, 32'h10);
    wr(3'd4, 32'hFF);
    // R6 NAK hold and flush
    wr(3'd3, 32'h01);
    for (int i = 0; i < 5; i++) wr(3'd0, 32'h50 + i);
    send_one("R6", 8'h50, 1'b1);
    rd(3'd4, v); chk("R6", v, 32'h01);
    chk("R6", {31'h0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R6", {31'h0, tx_valid}, 32'h0);
    rd(3'd2, v); chk("R6", v, 32'h0);
    wr(3'd1, 32'hC0);
    rd(3'd2, v); chk("R6", v, 32'h10);
    rd(3'd1, v); chk("R6", v, 32'h40);
    wr(3'd0, 32'h77);
    send_one("R6", 8'h77, 1'b0);
    wr(3'd4, 32'hFF); wr(3'd3, 32'h0);
    // R13 disable keeps contents
    wr(3'd0, 32'h81); wr(3'd0, 32'h82);
    wr(3'd1, 32'h00);
    chk("R13", {31'h0, tx_valid}, 32'h0);
    rd(3'd2, v); chk("R13", v, 32'h0);
    wr(3'd1, 32'h40);
    send_one("R13", 8'h81, 1'b0);
    send_one("R13", 8'h82, 1'b0);
    rd(3'd2, v); chk("R13", v, 32'h10);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule